// File: doc/BRIEF.md
# Self-Synchronous 64b66b Payload Scrambler and Descrambler

This block holds the two payload datapaths of a 64b66b line coder. The transmit lane takes a 64-bit payload word with a valid strobe and returns it scrambled, one clock later, with a matching valid. The receive lane takes a scrambled word and returns the original payload, also one clock later. Each lane keeps the 58 most recent line bits between words. All 64 bit-shifts of a word are worked out in a single cycle by an unrolled chain of stages.

The scrambling polynomial is x^58 + x^39 + 1, applied least-significant bit first. The transmit lane works in feedback form: every scrambled bit goes back into its own history. The receive lane works in feed-forward form: every received line bit goes into its history. Because of this, the receiver locks to the transmitter once 58 line bits have passed, whatever either history held beforehand. A 2-bit sync header travels next to each payload, gets the same one-cycle delay, and is never scrambled. Block alignment, gearboxing and header validation are handled elsewhere.

Top module: `scr66_pair`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both valid outputs, both payload outputs and both header outputs to zero, and loads both 58-bit histories with all ones. A zero payload sent first after reset is therefore scrambled against an all-ones history.
- R2: The transmit lane handles payload bit 0 first and bit 63 last. Each output bit is y[n] = x[n] ^ y[n-39] ^ y[n-58], where y counts line bits across word boundaries.
- R3: The receive lane handles received bit 0 first. Each output bit is x[n] = y[n] ^ y[n-39] ^ y[n-58], where y is the received line stream across word boundaries.
- R4: The result for a word with valid high appears on the data outputs one clock after it is presented. Each valid output equals the matching valid input from the previous clock.
- R5: The 2-bit header presented with a valid word appears unchanged on the lane's header output in the same cycle as that word's payload result.
- R6: On a cycle where a lane's valid input is low, that lane's payload output, header output and history keep their values. The next valid word continues the stream as if the idle cycle had not happened.
- R7: After the receive lane has taken in one full valid word of the transmit lane's output, it reproduces the original payload exactly, even when its history did not match the transmitter's beforehand.
- R8: When both lanes start from reset and the receive lane is given every transmit output word in order, the receive output equals the original payload word for word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both lanes |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid_i | input | 1 | Transmit payload word is valid |
| tx_hdr_i | input | 2 | Sync header sent with the transmit word |
| tx_data_i | input | 64 | Plain payload to scramble, bit 0 sent first |
| tx_valid_o | output | 1 | Scrambled word is valid |
| tx_hdr_o | output | 2 | Delayed transmit header |
| tx_data_o | output | 64 | Scrambled payload |
| rx_valid_i | input | 1 | Received payload word is valid |
| rx_hdr_i | input | 2 | Sync header received with the word |
| rx_data_i | input | 64 | Scrambled payload from the line, bit 0 first |
| rx_valid_o | output | 1 | Descrambled word is valid |
| rx_hdr_o | output | 2 | Delayed receive header |
| rx_data_o | output | 64 | Recovered plain payload |

## Verification
The hardest case to reach from the ports is a receiver whose history does not match the transmitter's. Normally both lanes leave reset with the same all-ones contents and stay locked. To break that, the stimulus runs the transmit lane for several valid words while the receive valid is held low, so the transmitter's history moves on and the receiver's stays where it was. The next word the receiver takes is compared against an independent feed-forward model started from that stale history. Every later word must then equal the original payload exactly.

// File: rtl/scr66_pkg.sv
package scr66_pkg;

  localparam int DEF_PAYLOAD_W = 64;
  localparam int DEF_HIST_W    = 58;
  localparam int DEF_HDR_W     = 2;
  // Stage indices of the two taps: stage k holds the line bit k+1 positions back.
  localparam int DEF_TAP_NEAR  = 38;
  localparam int DEF_TAP_FAR   = 57;

  // One line bit of the x^58 + x^39 + 1 relation.
  function automatic logic line_bit(input logic din, input logic near, input logic far);
    return din ^ near ^ far;
  endfunction

endpackage

// File: rtl/scr66_unroll.sv
module scr66_unroll
  import scr66_pkg::*;
#(
  parameter int PAYLOAD_W = DEF_PAYLOAD_W,
  parameter int HIST_W    = DEF_HIST_W,
  parameter int TAP_NEAR  = DEF_TAP_NEAR,
  parameter int TAP_FAR   = DEF_TAP_FAR,
  parameter bit FEED_FWD  = 1'b0
) (
  input  logic [HIST_W-1:0]    hist_i,
  input  logic [PAYLOAD_W-1:0] data_i,
  output logic [PAYLOAD_W-1:0] data_o,
  output logic [HIST_W-1:0]    hist_o
);

  // stg[g] is the history seen by bit g; stage 0 is the most recent line bit.
  logic [HIST_W-1:0] stg [PAYLOAD_W+1];

  assign stg[0] = hist_i;

  for (genvar g = 0; g < PAYLOAD_W; g++) begin : g_bit
    logic res_bit;
    assign res_bit   = line_bit(data_i[g], stg[g][TAP_NEAR], stg[g][TAP_FAR]);
    assign data_o[g] = res_bit;
    if (FEED_FWD) begin : g_ff
      // Receive side: the line bit itself enters the history.
      assign stg[g+1] = {stg[g][HIST_W-2:0], data_i[g]};
    end else begin : g_fb
      // Transmit side: the scrambled bit enters the history.
      assign stg[g+1] = {stg[g][HIST_W-2:0], res_bit};
    end
  end

  assign hist_o = stg[PAYLOAD_W];

endmodule

// File: rtl/scr66_lane.sv
module scr66_lane
  import scr66_pkg::*;
#(
  parameter int PAYLOAD_W = DEF_PAYLOAD_W,
  parameter int HIST_W    = DEF_HIST_W,
  parameter int HDR_W     = DEF_HDR_W,
  parameter int TAP_NEAR  = DEF_TAP_NEAR,
  parameter int TAP_FAR   = DEF_TAP_FAR,
  parameter bit FEED_FWD  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [HDR_W-1:0]     hdr_i,
  input  logic [PAYLOAD_W-1:0] data_i,
  output logic                 valid_o,
  output logic [HDR_W-1:0]     hdr_o,
  output logic [PAYLOAD_W-1:0] data_o
);

  localparam int OLDEST_IN_WORD = PAYLOAD_W - HIST_W;

  logic [HIST_W-1:0]    hist_q;
  logic [HIST_W-1:0]    hist_nx;
  logic [PAYLOAD_W-1:0] word_nx;
  logic                 advance;

  assign advance = valid_i;

  scr66_unroll #(
    .PAYLOAD_W (PAYLOAD_W),
    .HIST_W    (HIST_W),
    .TAP_NEAR  (TAP_NEAR),
    .TAP_FAR   (TAP_FAR),
    .FEED_FWD  (FEED_FWD)
  ) u_unroll (
    .hist_i (hist_q),
    .data_i (data_i),
    .data_o (word_nx),
    .hist_o (hist_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= '1;
      valid_o <= 1'b0;
      hdr_o   <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (advance) begin
        hist_q <= hist_nx;
        data_o <= word_nx;
        hdr_o  <= hdr_i;
      end
    end
  end

  AST_RESET_SEED: assert property (@(posedge clk)
    rst |=> (hist_q == '1) && !valid_o && (data_o == '0) && (hdr_o == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    valid_o == $past(valid_i)); // R4

  AST_HDR_CARRY: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> hdr_o == $past(hdr_i)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(data_o) && $stable(hdr_o) && $stable(hist_q)); // R6

  if (FEED_FWD) begin : g_ff_chk
    AST_RX_HIST_FROM_LINE: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> (hist_q[0] == $past(data_i[PAYLOAD_W-1]))
               && (hist_q[HIST_W-1] == $past(data_i[OLDEST_IN_WORD]))); // R3
  end else begin : g_fb_chk
    AST_TX_HIST_FROM_OUTPUT: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (hist_q[0] == data_o[PAYLOAD_W-1])
               && (hist_q[HIST_W-1] == data_o[OLDEST_IN_WORD])); // R2
  end

endmodule

// File: rtl/scr66_pair.sv
module scr66_pair
  import scr66_pkg::*;
#(
  parameter int PAYLOAD_W = DEF_PAYLOAD_W,
  parameter int HIST_W    = DEF_HIST_W,
  parameter int HDR_W     = DEF_HDR_W,
  parameter int TAP_NEAR  = DEF_TAP_NEAR,
  parameter int TAP_FAR   = DEF_TAP_FAR
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_valid_i,
  input  logic [HDR_W-1:0]     tx_hdr_i,
  input  logic [PAYLOAD_W-1:0] tx_data_i,
  output logic                 tx_valid_o,
  output logic [HDR_W-1:0]     tx_hdr_o,
  output logic [PAYLOAD_W-1:0] tx_data_o,
  input  logic                 rx_valid_i,
  input  logic [HDR_W-1:0]     rx_hdr_i,
  input  logic [PAYLOAD_W-1:0] rx_data_i,
  output logic                 rx_valid_o,
  output logic [HDR_W-1:0]     rx_hdr_o,
  output logic [PAYLOAD_W-1:0] rx_data_o
);

  scr66_lane #(
    .PAYLOAD_W (PAYLOAD_W),
    .HIST_W    (HIST_W),
    .HDR_W     (HDR_W),
    .TAP_NEAR  (TAP_NEAR),
    .TAP_FAR   (TAP_FAR),
    .FEED_FWD  (1'b0)
  ) u_tx (
    .clk     (clk),
    .rst     (rst),
    .valid_i (tx_valid_i),
    .hdr_i   (tx_hdr_i),
    .data_i  (tx_data_i),
    .valid_o (tx_valid_o),
    .hdr_o   (tx_hdr_o),
    .data_o  (tx_data_o)
  );

  scr66_lane #(
    .PAYLOAD_W (PAYLOAD_W),
    .HIST_W    (HIST_W),
    .HDR_W     (HDR_W),
    .TAP_NEAR  (TAP_NEAR),
    .TAP_FAR   (TAP_FAR),
    .FEED_FWD  (1'b1)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .valid_i (rx_valid_i),
    .hdr_i   (rx_hdr_i),
    .data_i  (rx_data_i),
    .valid_o (rx_valid_o),
    .hdr_o   (rx_hdr_o),
    .data_o  (rx_data_o)
  );

endmodule

// File: tb/sim_scr66_pair.sv
`timescale 1ns/1ps
module sim_scr66_pair;

  localparam int W = 64;
  localparam int H = 58;

  localparam logic [65:0] VEC [0:7] = '{
    {2'b01, 64'h0000_0000_0000_0000},
    {2'b10, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b01, 64'h0123_4567_89AB_CDEF},
    {2'b10, 64'hAAAA_5555_AAAA_5555},
    {2'b01, 64'h0000_0000_0000_0001},
    {2'b10, 64'h8000_0000_0000_0000},
    {2'b00, 64'hDEAD_BEEF_0BAD_F00D},
    {2'b11, 64'h0000_0000_0000_0078}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_valid_i = 1'b0, rx_valid_i = 1'b0;
  logic [1:0] tx_hdr_i = '0, rx_hdr_i = '0;
  logic [63:0] tx_data_i = '0, rx_data_i = '0;
  logic tx_valid_o, rx_valid_o;
  logic [1:0] tx_hdr_o, rx_hdr_o;
  logic [63:0] tx_data_o, rx_data_o;

  int compared = 0;
  int mismatched = 0;

  // Bench history: bit j is the line bit at time j, bit 0 the oldest of the window.
  logic [H-1:0] tx_m = '1;
  logic [H-1:0] rx_m = '1;

  always #5 clk = ~clk;

  scr66_pair u0 (
    .clk(clk), .rst(rst),
    .tx_valid_i(tx_valid_i), .tx_hdr_i(tx_hdr_i), .tx_data_i(tx_data_i),
    .tx_valid_o(tx_valid_o), .tx_hdr_o(tx_hdr_o), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_hdr_i(rx_hdr_i), .rx_data_i(rx_data_i),
    .rx_valid_o(rx_valid_o), .rx_hdr_o(rx_hdr_o), .rx_data_o(rx_data_o)
  );

  // Line stream model: n indexes a window of H old bits followed by W new ones.
  function automatic logic [W-1:0] mdl(input logic [H-1:0] old, input logic [W-1:0] x,
                                       input bit ff, output logic [H-1:0] nold);
    logic [H+W-1:0] w;
    logic [W-1:0] r;
    w = '0;
    w[H-1:0] = old;
    for (int n = H; n < H + W; n++) begin
      r[n-H] = x[n-H] ^ w[n-39] ^ w[n-58];
      w[n] = ff ? x[n-H] : r[n-H];
    end
    nold = w[H+W-1:W];
    return r;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string rq);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step(input logic tv, input logic rv, input logic [63:0] x, input logic [1:0] h,
                      input logic [63:0] junk, input string txtag, input string rxtag,
                      input string rtag);
    logic [63:0] y, xb, ptd, prd;
    logic [1:0] pth, prh;
    logic [H-1:0] nt, nr;
    y  = mdl(tx_m, x, 1'b0, nt);
    xb = mdl(rx_m, y, 1'b1, nr);
    if (tv) tx_m = nt;
    if (rv) rx_m = nr;
    ptd = tx_data_o; prd = rx_data_o; pth = tx_hdr_o; prh = rx_hdr_o;
    tx_valid_i = tv; rx_valid_i = rv;
    tx_data_i = tv ? x : junk;  tx_hdr_i = tv ? h : ~h;
    rx_data_i = rv ? y : ~junk; rx_hdr_i = rv ? h : ~h;
    @(negedge clk);
    chk({63'd0, tx_valid_o}, {63'd0, tv}, "R4");
    chk({63'd0, rx_valid_o}, {63'd0, rv}, "R4");
    if (tv) begin
      chk(tx_data_o, y, txtag);
      chk({62'd0, tx_hdr_o}, {62'd0, h}, "R5");
    end else begin
      chk(tx_data_o, ptd, "R6");
      chk({62'd0, tx_hdr_o}, {62'd0, pth}, "R6");
    end
    if (rv) begin
      chk(rx_data_o, xb, rxtag);
      chk({62'd0, rx_hdr_o}, {62'd0, h}, "R5");
      if (rtag != "") chk(rx_data_o, x, rtag);
    end else begin
      chk(rx_data_o, prd, "R6");
      chk({62'd0, rx_hdr_o}, {62'd0, prh}, "R6");
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tx_valid_i = 1'b0; rx_valid_i = 1'b0;
    tx_m = '1; rx_m = '1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk({63'd0, tx_valid_o}, 64'd0, "R1");
    chk({63'd0, rx_valid_o}, 64'd0, "R1");
    chk(tx_data_o, 64'd0, "R1");
    chk(rx_data_o, 64'd0, "R1");
    chk({60'd0, tx_hdr_o, rx_hdr_o}, 64'd0, "R1");
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog R4: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first word after reset is scrambled against the all-ones seed.
    step(1'b1, 1'b1, 64'd0, 2'b01, 64'd0, "R1", "R3", "R8");
    for (int k = 0; k < 8; k++)
      step(1'b1, 1'b1, VEC[k][63:0], VEC[k][65:64], 64'd0, "R2", "R3", "R8");
    // R6: idle cycles in the middle of a stream.
    step(1'b0, 1'b0, 64'd0, 2'b10, 64'h5A5A_F0F0_1234_9876, "R2", "R3", "");
    step(1'b1, 1'b1, 64'hCAFE_0000_FACE_1111, 2'b10, 64'd0, "R6", "R6", "R8");
    step(1'b0, 1'b0, 64'd0, 2'b01, 64'hFFFF_0000_FFFF_0000, "R2", "R3", "");
    step(1'b0, 1'b0, 64'd0, 2'b01, 64'h0F0F_0F0F_0F0F_0F0F, "R2", "R3", "");
    step(1'b1, 1'b1, 64'h7777_8888_9999_AAAA, 2'b01, 64'd0, "R6", "R6", "R8");
    // R7: transmitter runs ahead while the receiver is idle.
    step(1'b1, 1'b0, 64'h1111_2222_3333_4444, 2'b01, 64'hBAD0_BAD0_BAD0_BAD0, "R2", "R3", "");
    step(1'b1, 1'b0, 64'h5555_6666_7777_8888, 2'b10, 64'h0123_0123_0123_0123, "R2", "R3", "");
    step(1'b1, 1'b0, 64'h9999_AAAA_BBBB_CCCC, 2'b01, 64'hFEDC_FEDC_FEDC_FEDC, "R2", "R3", "");
    step(1'b1, 1'b1, 64'hDDDD_EEEE_FFFF_0000, 2'b10, 64'd0, "R2", "R3", "");
    step(1'b1, 1'b1, 64'h0000_0000_0000_0000, 2'b01, 64'd0, "R2", "R3", "R7");
    step(1'b1, 1'b1, 64'h0BAD_CAFE_DEAD_BEEF, 2'b10, 64'd0, "R2", "R3", "R7");
    step(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01, 64'd0, "R2", "R3", "R7");
    // R1: reset in the middle of a stream reloads the seed.
    do_reset();
    step(1'b1, 1'b1, 64'd0, 2'b01, 64'd0, "R1", "R1", "R8");
    step(1'b1, 1'b1, 64'h8000_0000_0000_0001, 2'b10, 64'd0, "R2", "R3", "R8");
    tx_valid_i = 1'b0; rx_valid_i = 1'b0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule